// File: doc/BRIEF.md
# Three-Wire Serial Register Writer

This block is a control-port master for an external converter that is configured through a three-wire write-only port made up of a serial data line, a serial clock line and a latch line. A client hands it a 7-bit register address and a 9-bit register value through a valid/ready handshake. The block packs the two into one 16-bit frame, clocks the frame out one bit at a time, and then raises the latch line to commit the write inside the converter.

Bit timing comes from a clock-enable divider. The parameter `HALF_DIV` gives the number of system clocks that each clock level lasts, so the integrator picks it to meet the converter's minimum phase time (about 1 µs) at the system clock in use. Between frames the port parks with data and clock both high and the latch low. The block never reads anything back and reports no errors.

Top module: `tw_reg_writer`

## Requirements
- R1: The frame holds the address in bits 15:9 and the value in bits 8:0. The 16 bits captured on the rising serial-clock edges equal {address, value}.
- R2: Bits leave the block most significant bit first. Frame bit 15 is presented before the first rising clock edge and frame bit 0 before the sixteenth.
- R3: The serial data line changes only while the serial clock is low, or when the clock falls. It is stable through every high clock phase of the shift.
- R4: Every low level of the serial clock during a frame, and every high level between two bits, lasts exactly `HALF_DIV` system clocks.
- R5: After the sixteenth rising clock edge the latch line goes high for exactly `HALF_DIV` system clocks while the clock stays high. There is exactly one latch pulse per accepted request.
- R6: The latch line stays low for the whole shift phase of a frame.
- R7: When idle, serial data and serial clock are high, the latch is low and `req_ready` is high.
- R8: `req_ready` falls in the cycle after a request is accepted and stays low until the idle state is restored. A `req_valid` pulse raised while `req_ready` is low is ignored and produces no frame.
- R9: A synchronous reset returns the lines to the idle state at once, including in the middle of a frame, and abandons the frame without any latch pulse.
- R10: A new request presented as soon as `req_ready` returns is accepted with no dead cycles, so frames can follow each other directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 7 | Converter register address |
| req_data | input | 9 | Value to write |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line |
| ser_latch | output | 1 | Latch (commit) line |

## Verification
Directed frames of all ones, all zeros and alternating patterns in the address and the value expose a swapped field boundary, a wrong shift direction and a stuck data bit. About two dozen seeded random address/value pairs cover the remaining bit positions. A `req_valid` pulse raised during a busy frame tests that the handshake is honoured. Back-to-back requests tell a clean return to idle apart from a lost or merged frame, and a reset in the middle of a frame shows whether the shifter is left half-loaded or emits a stray latch.

// File: rtl/tw_reg_writer.sv
module tw_reg_writer #(
  parameter int HALF_DIV = 125,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_latch
);

  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_LATCH} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bit_idx;
  logic [FRAME_W-1:0] shreg;
  logic               sclk_q, sdat_q, slat_q;

  wire phase_end = (cnt == CNT_W'(HALF_DIV - 1));
  wire last_bit  = (bit_idx == BIT_W'(FRAME_W - 1));
  wire accept    = req_valid && req_ready;
  wire [FRAME_W-1:0] frame = {req_addr, req_data};

  assign req_ready = (st == S_IDLE);
  assign ser_data  = sdat_q;
  assign ser_clk   = sclk_q;
  assign ser_latch = slat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      sclk_q  <= 1'b1;
      sdat_q  <= 1'b1;
      slat_q  <= 1'b0;
    end else begin
      if (st != S_IDLE) cnt <= phase_end ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          shreg   <= frame;
          sdat_q  <= frame[FRAME_W-1];
          sclk_q  <= 1'b0;
          bit_idx <= '0;
          cnt     <= '0;
          st      <= S_LOW;
        end
        S_LOW: if (phase_end) begin
          sclk_q <= 1'b1;
          st     <= S_HIGH;
        end
        S_HIGH: if (phase_end) begin
          if (last_bit) begin
            slat_q <= 1'b1;
            st     <= S_LATCH;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            shreg   <= shreg << 1;
            sdat_q  <= shreg[FRAME_W-2];
            sclk_q  <= 1'b0;
            st      <= S_LOW;
          end
        end
        S_LATCH: if (phase_end) begin
          slat_q <= 1'b0;
          sdat_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_parked_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ser_clk && ser_data && !ser_latch));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_data_stable_high_R3: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk) && !ser_latch && !$past(ser_latch) && !req_ready) |-> $stable(ser_data));

  assert_latch_clock_high_R5: assert property (@(posedge clk) disable iff (rst)
    ser_latch |-> ser_clk);

  assert_latch_low_in_shift_R6: assert property (@(posedge clk) disable iff (rst)
    !ser_clk |-> !ser_latch);

  assert_latch_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_latch) |-> !req_ready);

endmodule

// File: tb/tw_reg_writer_tb.sv
module tw_reg_writer_tb;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [6:0] req_addr = '0;
  logic [8:0] req_data = '0;
  logic ser_data, ser_clk, ser_latch;

  int n_chk = 0;
  int n_bad = 0;
  int latch_cnt = 0;
  logic [15:0] exp_word = '0;

  always #4 clk = ~clk;

  tw_reg_writer #(.HALF_DIV(H)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch));

  function automatic logic [15:0] pack_frame(input logic [6:0] a, input logic [8:0] d);
    logic [15:0] w;
    for (int i = 0; i < 9; i++) w[i] = d[i];
    for (int i = 0; i < 7; i++) w[9+i] = a[i];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor
  logic        p_clk = 1'b1, p_lat = 1'b0, p_dat = 1'b1, skip = 1'b0;
  int          clk_run = 0, lat_run = 0, bitcnt = 0;
  logic [15:0] cap = '0;
  always @(negedge clk) begin
    if (rst) begin
      bitcnt = 0; skip = 1'b1; clk_run = 0; lat_run = 0;
    end else begin
      if (ser_clk != p_clk) begin
        if (ser_clk && !skip) chk(clk_run == H, "R4 low level", clk_run, H);
        if (!ser_clk && bitcnt > 0 && !skip) chk(clk_run == H, "R4 high level", clk_run, H);
        if (!ser_clk) skip = 1'b0;
        if (ser_clk) begin cap = {cap[14:0], ser_data}; bitcnt++; end
        clk_run = 1;
      end else clk_run++;
      if (ser_clk && p_clk && !ser_latch && !p_lat && !req_ready && ser_data != p_dat) begin
        n_chk++; n_bad++;
        $display("FAIL R3 data moved in high phase actual=%0b expected=%0b", ser_data, p_dat);
      end
      if (!ser_clk && ser_latch) begin
        n_chk++; n_bad++;
        $display("FAIL R6 latch high during shift actual=1 expected=0");
      end
      if (ser_latch && !p_lat) begin
        latch_cnt++;
        chk(bitcnt == 16, "R2 bits before latch", bitcnt, 16);
        chk(cap == exp_word, "R1 frame", cap, exp_word);
        chk(ser_clk, "R5 clock high at latch", ser_clk, 1);
        lat_run = 1;
      end else if (ser_latch) lat_run++;
      else if (p_lat) begin
        chk(lat_run == H, "R5 latch width", lat_run, H);
        bitcnt = 0;
      end
    end
    p_clk = ser_clk; p_lat = ser_latch; p_dat = ser_data;
  end

  task automatic send(input logic [6:0] a, input logic [8:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_word = pack_frame(a, d);
    req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 ready low after accept", req_ready, 0);
  endtask

  task automatic wait_idle_check();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    chk(ser_clk && ser_data && !ser_latch, "R7 idle lines",
        {ser_clk, ser_data, ser_latch}, 3'b110);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    int lc;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R7 ready after reset", req_ready, 1);
    chk(ser_clk && ser_data && !ser_latch, "R7 lines after reset",
        {ser_clk, ser_data, ser_latch}, 3'b110);

    // directed patterns
    send(7'h7f, 9'h1ff); wait_idle_check();
    send(7'h00, 9'h000); wait_idle_check();
    send(7'h55, 9'h0aa); wait_idle_check();
    send(7'h2a, 9'h155); wait_idle_check();
    send(7'h40, 9'h001); wait_idle_check();
    chk(latch_cnt == 5, "R5 one latch per request", latch_cnt, 5);

    // request while busy must be ignored
    lc = latch_cnt;
    send(7'h11, 9'h022);
    repeat (10) @(negedge clk);
    req_addr = 7'h33; req_data = 9'h044; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle_check();
    repeat (6 * H) @(negedge clk);
    chk(latch_cnt == lc + 1, "R8 busy request ignored", latch_cnt, lc + 1);
    chk(req_ready, "R8 ready stays high with no request", req_ready, 1);

    // back-to-back
    lc = latch_cnt;
    send(7'h12, 9'h034);
    send(7'h56, 9'h078);
    send(7'h1a, 9'h1bc);
    wait_idle_check();
    chk(latch_cnt == lc + 3, "R10 back-to-back frames", latch_cnt, lc + 3);

    // reset mid-frame
    lc = latch_cnt;
    send(7'h3c, 9'h0f0);
    repeat (5 * H) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(req_ready && ser_clk && ser_data && !ser_latch, "R9 reset mid-frame",
        {req_ready, ser_clk, ser_data, ser_latch}, 4'b1110);
    rst = 1'b0;
    repeat (40 * H) @(negedge clk);
    chk(latch_cnt == lc, "R9 abandoned frame not latched", latch_cnt, lc);
    send(7'h05, 9'h10a); wait_idle_check();

    // random frames
    for (int k = 0; k < 25; k++) begin
      send(7'($urandom), 9'($urandom));
      if (($urandom % 2) == 0) wait_idle_check();
    end
    wait_idle_check();
    report();
  end
endmodule